// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI device function. A host-side register port presents a byte offset, an access size of 1, 2 or 4 bytes, a write flag and write data. Reads return the addressed bytes right-justified. Every write goes through a policy that is fixed for each register. The identity fields are elaboration-time parameters: vendor, device, revision, class code, status, interrupt pin and line, the initial base address values and one size per base address register (BAR). They are loaded on reset.

The block carries out the BAR sizing probe, in which writing all ones reads back a size mask that keeps the BAR's type bits. It also keeps the type bits of a BAR when an address is written: the low two bits of an I/O BAR and the low four bits of a memory BAR. The expansion ROM base register takes its own probe value. Only a few header fields accept narrow writes. Any access that is illegal, misaligned or out of range raises an error pulse and changes nothing. When software moves an I/O BAR, a one-cycle update pulse gives external decode logic the BAR index and the new base.

All results are registered. Read data, the error pulse and the BAR update pulse appear in the cycle after the access is presented. Read data holds its value until the next legal read.

Top module: `pci_cfg_header`

## Requirements
- R1: On reset the header dwords hold: offset 0x00 = {DEVICE_ID, VENDOR_ID}; 0x04 = {STATUS_INIT, 16'h0}; 0x08 = {CLASS_CODE, REVISION_ID}; 0x10 + 4*i = BAR i initial value (i = 0..5); 0x30 = ROM_INIT; 0x3C = {16'h0, INT_PIN, INT_LINE}. Every other byte is zero. The read data, error and update outputs are zero.
- R2: A read (acc_write = 0) of size 1, 2 or 4 at an aligned offset below 64 returns, one cycle later, the addressed bytes zero-extended with the lowest address in bits 7:0. acc_rdata changes only on a legal read.
- R3: A read whose size is not 1, 2 or 4 raises acc_error in the next cycle and leaves acc_rdata unchanged.
- R4: An access at an offset of 64 or more, or at an offset that is not a multiple of its size, raises acc_error in the next cycle and is ignored.
- R5: A write whose size is not 1, 2 or 4 (3 included) raises acc_error and changes no register.
- R6: A 1-byte write is accepted only at 0x0C (cache line size) and 0x3C (interrupt line). Anywhere else it raises acc_error and changes nothing.
- R7: A 2-byte write is accepted only at 0x04 (command) and 0x0C, where it writes both bytes. Anywhere else it raises acc_error and changes nothing.
- R8: A 4-byte write at 0x04 replaces bits 15:0 (command) and leaves bits 31:16 (status) unchanged.
- R9: A 4-byte write of 32'hFFFFFFFF to a BAR at 0x10..0x24 stores ~(size-1) | (old & L), where size is that BAR's size parameter. L is 32'h3 when bit 0 of the stored BAR is 1 (I/O) and 32'hF otherwise (memory).
- R10: Any other 4-byte BAR write stores (wdata & ~L) | (old & L), with L as in R9.
- R11: A 4-byte write of 32'hFFFFFFFE at 0x30 makes the register read 32'hFFFFFFFF. Any other 4-byte value written there is stored unchanged.
- R12: A non-probe 4-byte write to an I/O BAR pulses bar_upd_valid for exactly one cycle, in the cycle after the write. bar_upd_index then holds (offset-0x10)>>2 and bar_upd_base holds the new stored value. No other access pulses bar_upd_valid.
- R13: A 4-byte write to any offset other than 0x04, the six BARs and 0x30 raises acc_error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset into the header |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, right-justified |
| acc_rdata | output | 32 | Registered read data |
| acc_error | output | 1 | One-cycle pulse for an illegal access |
| bar_upd_valid | output | 1 | One-cycle pulse: an I/O BAR was moved |
| bar_upd_index | output | 3 | Index of the moved BAR |
| bar_upd_base | output | 32 | New stored value of that BAR |

## Verification
A register update and the decode of the next access share a cycle. A write commits at one edge, and a read issued at the very next edge must see the new value. That same edge can also produce the update pulse of the previous write and the error of a following illegal access. The bench provokes this by issuing accesses back to back with no idle cycle, including a BAR probe or address write followed at once by a read of that BAR. It compares every output against a bench-side model of the header that applies the write policy in issue order.

// File: rtl/cfg_pkg.sv
// Shared types and fixed header offsets of the configuration register file.
// Assumes a 64-byte header and an 8-bit byte offset on the access port.
package cfg_pkg;
    localparam int CFG_BYTES  = 64;
    localparam int CFG_DWORDS = CFG_BYTES / 4;
    localparam int NUM_BARS   = 6;
    localparam int OFS_W      = 8;
    localparam int DW_W       = $clog2(CFG_DWORDS);
    localparam int BARIDX_W   = 3;

    typedef logic [OFS_W-1:0] ofs_t;

    localparam ofs_t OFS_CMD      = 8'h04;
    localparam ofs_t OFS_CLS      = 8'h0C;
    localparam ofs_t OFS_BAR0     = 8'h10;
    localparam ofs_t OFS_BAR_LAST = 8'h24;
    localparam ofs_t OFS_ROM      = 8'h30;
    localparam ofs_t OFS_INTLINE  = 8'h3C;

    typedef enum logic [2:0] {
        K_NONE, K_READ, K_BYTE, K_HALF, K_CMD, K_BAR, K_ROM
    } acc_kind_e;
endpackage

// File: rtl/cfg_access_decode.sv
// Classifies one access against the per-register write policy and the
// read legality rules. Purely combinational; K_NONE means illegal.
module cfg_access_decode
    import cfg_pkg::*;
(
    input  ofs_t                offset,
    input  logic [2:0]          size,
    input  logic                write,
    output logic                legal,
    output acc_kind_e           kind,
    output logic [DW_W-1:0]     dw_idx,
    output logic [BARIDX_W-1:0] bar_idx
);
    ofs_t bar_rel;
    logic in_range;
    logic aligned;

    // Decode range, alignment and target register of the access.
    always_comb begin
        bar_rel  = offset - OFS_BAR0;
        bar_idx  = bar_rel[BARIDX_W+1:2];
        dw_idx   = offset[DW_W+1:2];
        in_range = offset < ofs_t'(CFG_BYTES);
        case (size)
            3'd1:    aligned = 1'b1;
            3'd2:    aligned = ~offset[0];
            3'd4:    aligned = offset[1:0] == 2'b00;
            default: aligned = 1'b0;
        endcase
        kind = K_NONE;
        if (!write) begin
            if (in_range && aligned) kind = K_READ;
        end else begin
            case (size)
                3'd1: if (offset == OFS_CLS || offset == OFS_INTLINE) kind = K_BYTE;
                3'd2: if (offset == OFS_CMD || offset == OFS_CLS) kind = K_HALF;
                3'd4: begin
                    if (offset == OFS_CMD)
                        kind = K_CMD;
                    else if (offset >= OFS_BAR0 && offset <= OFS_BAR_LAST && offset[1:0] == 2'b00)
                        kind = K_BAR;
                    else if (offset == OFS_ROM)
                        kind = K_ROM;
                end
                default: kind = K_NONE;
            endcase
        end
        legal = kind != K_NONE;
    end
endmodule

// File: rtl/cfg_bar_calc.sv
// Computes the next value of a BAR for a 4-byte write: sizing probe or
// address write, both keeping the read-only type bits of the stored value.
// Assumes bit 0 of the stored value marks an I/O BAR.
module cfg_bar_calc (
    input  logic [31:0] old_val,
    input  logic [31:0] wdata,
    input  logic [31:0] span,
    output logic [31:0] next_val,
    output logic        is_io,
    output logic        is_probe
);
    logic [31:0] keep_mask;

    // Select the locked low bits and form the new BAR contents.
    always_comb begin
        is_io     = old_val[0];
        is_probe  = wdata == 32'hFFFF_FFFF;
        keep_mask = is_io ? 32'h0000_0003 : 32'h0000_000F;
        if (is_probe)
            next_val = ~(span - 32'd1) | (old_val & keep_mask);
        else
            next_val = (wdata & ~keep_mask) | (old_val & keep_mask);
    end
endmodule

// File: rtl/cfg_read_align.sv
// Extracts the addressed bytes of a dword for a read and zero-extends them.
// Assumes the caller has already checked size and alignment.
module cfg_read_align (
    input  logic [31:0] dword,
    input  logic [1:0]  lane,
    input  logic [2:0]  size,
    output logic [31:0] data
);
    logic [31:0] shifted;

    // Shift the addressed byte lane down and mask to the access width.
    always_comb begin
        shifted = dword >> {lane, 3'b000};
        case (size)
            3'd1:    data = {24'h0, shifted[7:0]};
            3'd2:    data = {16'h0, shifted[15:0]};
            default: data = shifted;
        endcase
    end
endmodule

// File: rtl/pci_cfg_header.sv
// Type-0 configuration header register file for one device function.
// Holds 16 dwords loaded from parameters on reset, serves 1/2/4-byte reads
// and applies a fixed write policy per register. All outputs are registered
// and appear one cycle after the access. Assumes one access per cycle.
module pci_cfg_header
    import cfg_pkg::*;
#(
    parameter logic [15:0]           VENDOR_ID   = 16'h1A2B,
    parameter logic [15:0]           DEVICE_ID   = 16'h3C4D,
    parameter logic [7:0]            REVISION_ID = 8'h02,
    parameter logic [23:0]           CLASS_CODE  = 24'h020000,
    parameter logic [15:0]           STATUS_INIT = 16'h0290,
    parameter logic [7:0]            INT_PIN     = 8'h01,
    parameter logic [7:0]            INT_LINE    = 8'h0B,
    parameter logic [31:0]           ROM_INIT    = 32'h0,
    parameter logic [NUM_BARS*32-1:0] BAR_INIT   = {32'h0, 32'h0, 32'h0, 32'h1, 32'h1, 32'h8},
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE   = {32'h0, 32'h0, 32'h0, 32'h40, 32'h100, 32'h1000}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [7:0]          acc_offset,
    input  logic [2:0]          acc_size,
    input  logic [31:0]         acc_wdata,
    output logic [31:0]         acc_rdata,
    output logic                acc_error,
    output logic                bar_upd_valid,
    output logic [2:0]          bar_upd_index,
    output logic [31:0]         bar_upd_base
);
    localparam int BAR_SLOTS = 1 << BARIDX_W;
    localparam int BAR_DW0   = int'(OFS_BAR0) / 4;
    localparam int ROM_DW    = int'(OFS_ROM) / 4;
    localparam int INT_DW    = int'(OFS_INTLINE) / 4;

    logic [31:0]          cfg_mem [CFG_DWORDS];
    logic [31:0]          size_tab [BAR_SLOTS];
    logic                 legal;
    acc_kind_e            kind;
    logic [DW_W-1:0]      dw_idx;
    logic [BARIDX_W-1:0]  bar_idx;
    logic [31:0]          cur_dword;
    logic [31:0]          rd_data;
    logic [31:0]          bar_next;
    logic                 bar_io;
    logic                 bar_probe;
    logic [31:0]          rom_next;

    // Reset image of one header dword, built from the parameters.
    function automatic logic [31:0] init_dword(input int idx);
        if (idx == 0)                                  return {DEVICE_ID, VENDOR_ID};
        if (idx == 1)                                  return {STATUS_INIT, 16'h0};
        if (idx == 2)                                  return {CLASS_CODE, REVISION_ID};
        if (idx >= BAR_DW0 && idx < BAR_DW0 + NUM_BARS) return BAR_INIT[(idx-BAR_DW0)*32 +: 32];
        if (idx == ROM_DW)                             return ROM_INIT;
        if (idx == INT_DW)                             return {16'h0, INT_PIN, INT_LINE};
        return 32'h0;
    endfunction

    // Per-slot BAR size table; slots past the last BAR read as zero.
    for (genvar g = 0; g < BAR_SLOTS; g++) begin : g_size
        if (g < NUM_BARS) begin : g_real
            assign size_tab[g] = BAR_SIZE[g*32 +: 32];
        end else begin : g_pad
            assign size_tab[g] = 32'h0;
        end
    end

    cfg_access_decode u_dec (
        .offset  (acc_offset),
        .size    (acc_size),
        .write   (acc_write),
        .legal   (legal),
        .kind    (kind),
        .dw_idx  (dw_idx),
        .bar_idx (bar_idx)
    );

    assign cur_dword = cfg_mem[dw_idx];

    cfg_read_align u_rd (
        .dword (cur_dword),
        .lane  (acc_offset[1:0]),
        .size  (acc_size),
        .data  (rd_data)
    );

    cfg_bar_calc u_bar (
        .old_val  (cur_dword),
        .wdata    (acc_wdata),
        .span     (size_tab[bar_idx]),
        .next_val (bar_next),
        .is_io    (bar_io),
        .is_probe (bar_probe)
    );

    // ROM base: the probe value reads back as all ones.
    assign rom_next = (acc_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : acc_wdata;

    // Header storage, registered read data and the two event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_DWORDS; i++) cfg_mem[i] <= init_dword(i);
            acc_rdata     <= 32'h0;
            acc_error     <= 1'b0;
            bar_upd_valid <= 1'b0;
            bar_upd_index <= '0;
            bar_upd_base  <= 32'h0;
        end else begin
            acc_error     <= acc_valid && !legal;
            bar_upd_valid <= 1'b0;
            if (acc_valid && legal) begin
                case (kind)
                    K_READ: acc_rdata <= rd_data;
                    K_BYTE: cfg_mem[dw_idx][{acc_offset[1:0], 3'b000} +: 8] <= acc_wdata[7:0];
                    K_HALF: cfg_mem[dw_idx][{acc_offset[1], 4'b0000} +: 16] <= acc_wdata[15:0];
                    K_CMD:  cfg_mem[dw_idx][15:0] <= acc_wdata[15:0];
                    K_BAR: begin
                        cfg_mem[dw_idx] <= bar_next;
                        if (bar_io && !bar_probe) begin
                            bar_upd_valid <= 1'b1;
                            bar_upd_index <= bar_idx;
                            bar_upd_base  <= bar_next;
                        end
                    end
                    K_ROM:  cfg_mem[dw_idx] <= rom_next;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_header_chk.sv
// Protocol checker for the configuration header register file, bound to
// every instance of the top module. Observes ports only.
module cfg_header_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [7:0]  acc_offset,
    input logic [2:0]  acc_size,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        acc_error,
    input logic        bar_upd_valid,
    input logic [2:0]  bar_upd_index,
    input logic [31:0] bar_upd_base
);
    a_r3_bad_read_size: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !(acc_size == 3'd1 || acc_size == 3'd2 || acc_size == 3'd4))
        |=> (acc_error && $stable(acc_rdata)));

    a_r4_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_offset >= 8'd64) |=> (acc_error && !bar_upd_valid));

    a_r5_three_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_size == 3'd3) |=> acc_error);

    a_r2_rdata_held_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || acc_write) |=> $stable(acc_rdata));

    a_r9_probe_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_wdata == 32'hFFFF_FFFF) |=> !bar_upd_valid);

    a_r12_update_source: assert property (@(posedge clk) disable iff (!rst_n)
        bar_upd_valid |-> $past(acc_valid && acc_write && acc_size == 3'd4
                                && acc_offset >= 8'h10 && acc_offset <= 8'h24));

    a_r12_update_index: assert property (@(posedge clk) disable iff (!rst_n)
        bar_upd_valid |-> (bar_upd_index <= 3'd5 && !acc_error && bar_upd_base[0]));
endmodule

bind pci_cfg_header cfg_header_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_offset    (acc_offset),
    .acc_size      (acc_size),
    .acc_wdata     (acc_wdata),
    .acc_rdata     (acc_rdata),
    .acc_error     (acc_error),
    .bar_upd_valid (bar_upd_valid),
    .bar_upd_index (bar_upd_index),
    .bar_upd_base  (bar_upd_base)
);

// File: tb/tb_pci_cfg_header.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a bench model of the header built from the requirements.
module tb_pci_cfg_header;
    localparam logic [15:0]  T_VEN  = 16'h1A2B;
    localparam logic [15:0]  T_DEV  = 16'h3C4D;
    localparam logic [7:0]   T_REV  = 8'h02;
    localparam logic [23:0]  T_CLS  = 24'h020000;
    localparam logic [15:0]  T_STAT = 16'h0290;
    localparam logic [7:0]   T_PIN  = 8'h01;
    localparam logic [7:0]   T_LINE = 8'h0B;
    localparam logic [31:0]  T_ROM  = 32'h0;
    localparam logic [191:0] T_BINIT = {32'h0, 32'h0, 32'h0, 32'h1, 32'h1, 32'h8};
    localparam logic [191:0] T_BSIZE = {32'h0, 32'h0, 32'h0, 32'h40, 32'h100, 32'h1000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_offset = 8'h0;
    logic [2:0]  acc_size = 3'd0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] acc_rdata;
    logic        acc_error;
    logic        bar_upd_valid;
    logic [2:0]  bar_upd_index;
    logic [31:0] bar_upd_base;

    int nchecks = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [31:0] m [16];
    logic [31:0] exp_rdata;

    always #2 clk = ~clk;

    pci_cfg_header #(
        .VENDOR_ID(T_VEN), .DEVICE_ID(T_DEV), .REVISION_ID(T_REV),
        .CLASS_CODE(T_CLS), .STATUS_INIT(T_STAT), .INT_PIN(T_PIN),
        .INT_LINE(T_LINE), .ROM_INIT(T_ROM), .BAR_INIT(T_BINIT), .BAR_SIZE(T_BSIZE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_error(acc_error), .bar_upd_valid(bar_upd_valid),
        .bar_upd_index(bar_upd_index), .bar_upd_base(bar_upd_base)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m[i] = 32'h0;
        m[0]  = {T_DEV, T_VEN};
        m[1]  = {T_STAT, 16'h0};
        m[2]  = {T_CLS, T_REV};
        for (int i = 0; i < 6; i++) m[4+i] = T_BINIT[i*32 +: 32];
        m[12] = T_ROM;
        m[15] = {16'h0, T_PIN, T_LINE};
        exp_rdata = 32'h0;
    endtask

    // One access: model it, drive it, check the outputs one cycle later.
    task automatic acc(input logic wr, input logic [7:0] off, input logic [2:0] sz,
                       input logic [31:0] wd, input string force_tag);
        logic        e_err = 1'b1;
        logic        e_upd = 1'b0;
        logic [2:0]  e_idx = 3'd0;
        logic [31:0] e_base = 32'h0;
        logic [31:0] sh, old, low, nv;
        int          d = int'(off) / 4;
        int          lane = int'(off) % 4;
        string       t = "R4";
        if (!wr) begin
            if (!(sz == 1 || sz == 2 || sz == 4)) t = "R3";
            else if (off >= 64 || (int'(off) % int'(sz)) != 0) t = "R4";
            else begin
                e_err = 1'b0; t = "R2";
                sh = m[d] >> (8*lane);
                exp_rdata = (sz == 1) ? (sh & 32'hFF) : (sz == 2) ? (sh & 32'hFFFF) : sh;
            end
        end else begin
            case (sz)
                3'd1: begin
                    t = "R6";
                    if (off == 8'h0C || off == 8'h3C) begin e_err = 1'b0; m[d][8*lane +: 8] = wd[7:0]; end
                end
                3'd2: begin
                    t = "R7";
                    if (off == 8'h04 || off == 8'h0C) begin e_err = 1'b0; m[d][8*lane +: 16] = wd[15:0]; end
                end
                3'd4: begin
                    if (off == 8'h04) begin t = "R8"; e_err = 1'b0; m[1][15:0] = wd[15:0]; end
                    else if (off >= 8'h10 && off <= 8'h24 && lane == 0) begin
                        e_err = 1'b0;
                        old = m[d];
                        low = old[0] ? 32'h3 : 32'hF;
                        if (wd == 32'hFFFF_FFFF) begin
                            t = "R9";
                            nv = ~(T_BSIZE[(d-4)*32 +: 32] - 32'd1) | (old & low);
                        end else begin
                            t = old[0] ? "R12" : "R10";
                            nv = (wd & ~low) | (old & low);
                            if (old[0]) begin e_upd = 1'b1; e_idx = 3'(d-4); e_base = nv; end
                        end
                        m[d] = nv;
                    end else if (off == 8'h30) begin
                        t = "R11"; e_err = 1'b0;
                        m[12] = (wd == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : wd;
                    end else t = "R13";
                end
                default: t = "R5";
            endcase
        end
        if (force_tag != "") t = force_tag;
        acc_valid = 1'b1; acc_write = wr; acc_offset = off; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        check(t, "error", {31'h0, acc_error}, {31'h0, e_err});
        check(t, "rdata", acc_rdata, exp_rdata);
        check("R12", "upd_valid", {31'h0, bar_upd_valid}, {31'h0, e_upd});
        if (e_upd) begin
            check("R12", "upd_index", {29'h0, bar_upd_index}, {29'h0, e_idx});
            check("R12", "upd_base", bar_upd_base, e_base);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        check("R2", "idle rdata", acc_rdata, exp_rdata);
        check("R4", "idle error", {31'h0, acc_error}, 32'h0);
        check("R12", "idle upd", {31'h0, bar_upd_valid}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchecks++;
            $display("FAIL watchdog R2: actual hung expected finished");
            $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
            $finish;
        end
    end

    initial begin
        logic [2:0] sizes [8];
        logic [7:0] off;
        logic [31:0] wd;
        sizes = '{3'd1, 3'd2, 3'd4, 3'd4, 3'd4, 3'd3, 3'd0, 3'd5};
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        check("R1", "reset rdata", acc_rdata, 32'h0);
        check("R1", "reset error", {31'h0, acc_error}, 32'h0);
        check("R1", "reset upd", {31'h0, bar_upd_valid}, 32'h0);
        rst_n = 1'b1;
        // R1: reset image read through the port
        acc(1'b0, 8'h00, 3'd4, 32'h0, "R1");
        acc(1'b0, 8'h3D, 3'd1, 32'h0, "R1");
        acc(1'b0, 8'h0A, 3'd2, 32'h0, "R1");
        acc(1'b0, 8'h06, 3'd2, 32'h0, "R1");
        acc(1'b0, 8'h14, 3'd4, 32'h0, "R1");
        acc(1'b0, 8'h2C, 3'd4, 32'h0, "R1");
        // R6 / R7: narrow writes, legal and rejected, with read-back
        acc(1'b1, 8'h3C, 3'd1, 32'h0000_00A5, "");
        acc(1'b0, 8'h3C, 3'd4, 32'h0, "R6");
        acc(1'b1, 8'h00, 3'd1, 32'h0000_0055, "");
        acc(1'b0, 8'h00, 3'd4, 32'h0, "R6");
        acc(1'b1, 8'h0C, 3'd2, 32'h0000_4010, "");
        acc(1'b1, 8'h02, 3'd2, 32'h0000_FFFF, "");
        acc(1'b0, 8'h00, 3'd4, 32'h0, "R7");
        // R5: three-byte write ignored
        acc(1'b1, 8'h0C, 3'd3, 32'h00FF_FFFF, "");
        acc(1'b0, 8'h0C, 3'd4, 32'h0, "R5");
        // R8: dword write to command keeps status
        acc(1'b1, 8'h04, 3'd4, 32'hFFFF_1234, "");
        acc(1'b0, 8'h04, 3'd4, 32'h0, "R8");
        // R9 / R10 / R12: BAR probes and address writes, back to back reads
        acc(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF, "");
        acc(1'b0, 8'h10, 3'd4, 32'h0, "R9");
        acc(1'b1, 8'h14, 3'd4, 32'hFFFF_FFFF, "");
        acc(1'b0, 8'h14, 3'd4, 32'h0, "R9");
        acc(1'b1, 8'h14, 3'd4, 32'hABCD_0012, "");
        acc(1'b0, 8'h14, 3'd4, 32'h0, "R12");
        acc(1'b1, 8'h10, 3'd4, 32'h1234_567F, "");
        acc(1'b0, 8'h10, 3'd4, 32'h0, "R10");
        acc(1'b1, 8'h24, 3'd4, 32'hFFFF_FFFF, "");
        acc(1'b0, 8'h24, 3'd4, 32'h0, "R9");
        // R11: ROM probe value and plain value
        acc(1'b1, 8'h30, 3'd4, 32'hFFFF_FFFE, "");
        acc(1'b0, 8'h30, 3'd4, 32'h0, "R11");
        acc(1'b1, 8'h30, 3'd4, 32'h1234_5678, "");
        acc(1'b0, 8'h30, 3'd4, 32'h0, "R11");
        // R13: dword write to a read-only field
        acc(1'b1, 8'h00, 3'd4, 32'hDEAD_BEEF, "");
        acc(1'b1, 8'h08, 3'd4, 32'hDEAD_BEEF, "");
        acc(1'b0, 8'h08, 3'd4, 32'h0, "R13");
        // R3 / R4: bad sizes, misalignment, range
        acc(1'b0, 8'h00, 3'd0, 32'h0, "");
        acc(1'b0, 8'h04, 3'd5, 32'h0, "");
        acc(1'b0, 8'h01, 3'd2, 32'h0, "");
        acc(1'b0, 8'h02, 3'd4, 32'h0, "");
        acc(1'b0, 8'h40, 3'd1, 32'h0, "");
        acc(1'b1, 8'h44, 3'd4, 32'hFFFF_FFFF, "");
        idle();
        // Seeded random traffic
        for (int n = 0; n < 800; n++) begin
            if ($urandom_range(0, 9) < 7)
                off = 8'($urandom_range(0, 15) * 4 + (($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0));
            else
                off = 8'($urandom_range(0, 71));
            case ($urandom_range(0, 7))
                0, 1:    wd = 32'hFFFF_FFFF;
                2:       wd = 32'hFFFF_FFFE;
                default: wd = $urandom();
            endcase
            acc(($urandom_range(0, 9) < 6), off, sizes[$urandom_range(0, 7)], wd, "");
            if ($urandom_range(0, 7) == 0) idle();
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
        $finish;
    end
endmodule